// File: doc/BRIEF.md
# Five-Cycle Little-Endian Integer Core

This block is a small 32-bit processor that executes a subset of the classic three-format RISC integer instruction set. Each instruction passes through five fixed states. The first state issues a fetch and the second captures the returned word. The third state reads the operands and computes the result, the branch target and the address. The fourth state performs the one data access, if there is one. The fifth state writes the result back and advances the program counter. There is no pipelining, no delay slot and no exception logic.

The core drives a single memory port. Fetches and data accesses share that port. Read data arrives on the cycle after a read strobe. Memory is little-endian. A boot-select pin is sampled while reset is held and chooses one of two start addresses. The core holds 32 general registers internally.

Top module: `lecore_top`

## Requirements
- R1: The core issues an instruction fetch (memRd high, memAddr equal to the program counter) in the first cycle after reset is released and then exactly every fifth cycle. A non-load instruction raises no other read strobe, and it takes exactly five cycles.
- R2: The value of bootSel while rstN is low sets the first fetch address. Low gives ROM_BASE (default 0x4000) and high gives ALT_BASE (default 0xC000). Changing bootSel after reset has no effect.
- R3: An instruction with opcode 0 (bits 31:26) is R-type. It takes rs from bits 25:21, rt from bits 20:16, rd from bits 15:11 and the shift amount from bits 10:6, and it writes rd. The function field (bits 5:0) selects the operation: 0x20/0x21 add, 0x22/0x23 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than, 0x2B unsigned set-less-than, 0x00 shift left of rt, 0x02 logical right shift of rt, 0x03 arithmetic right shift of rt.
- R4: Immediate ALU instructions write rt and take a 16-bit immediate in bits 15:0. andi (0x0C), ori (0x0D) and xori (0x0E) zero-extend it. addi (0x08), addiu (0x09), slti (0x0A) and sltiu (0x0B) sign-extend it.
- R5: lui (0x0F) writes the immediate to bits 31:16 of rt and clears bits 15:0. lui 0x1234 followed by ori 0x9978 on the same register leaves 0x12349978.
- R6: A write that targets register 0 is discarded, and a read of register 0 always returns zero.
- R7: lw (0x23) and sw (0x2B) access the word at rs plus the sign-extended immediate, during the fourth cycle, with memBe = 4'hF. Byte 0 of the word (bits 7:0) sits at the lowest address. lw writes rt.
- R8: beq (0x04) and bne (0x05) compare rs with rt. When taken, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. No instruction in a delay slot executes.
- R9: j (0x02) and jal (0x03) jump to the upper four bits of PC+4 joined with the 26-bit index shifted left by two. jal also writes PC+4 to register 31.
- R10: memRd and memWr are never high together. memWr is high only during the data cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bootSel | input | 1 | Start address select, sampled while in reset |
| memAddr | output | 32 | Byte address for fetch or data access |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data, valid the cycle after memRd |
| memBe | output | 4 | Byte enables, all set on any access |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |

## Verification
The registers are visible only through stores, so every scenario ends by writing its results to memory. The bench then inspects the bytes of its memory model. The hardest case is register 0. To expose the discard, the bench preloads a marker at the result address, aims several kinds of writes at register 0, stores register 0 over the marker, and uses it as a source for a register that is later stored. Branch and jump coverage relies on sentinel writes placed in the skipped slots. Any fall-through or delay-slot execution then alters the stored values.

// File: rtl/lecore_pkg.sv
package lecore_pkg;
  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);
  localparam int LINK_REG  = REG_COUNT - 1;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_HIGH
  } aluOp_t;

  typedef enum logic [2:0] {
    ST_FETCH_ISSUE, ST_FETCH_CAPTURE, ST_EXECUTE, ST_DATA, ST_RETIRE
  } cycState_t;

  typedef struct packed {
    logic fetch;
    logic irLoad;
    logic exLoad;
    logic memRd;
    logic memWr;
    logic regWrite;
    logic wbSelMem;
    logic pcLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/lecore_alu.sv
module lecore_alu
  import lecore_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluOp_t         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [4:0]     shamt,
  output logic [W-1:0]   y
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      ALU_SLL:  y = b << shamt;
      ALU_SRL:  y = b >> shamt;
      ALU_SRA:  y = W'($signed(b) >>> shamt);
      ALU_HIGH: y = b << HALF;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/lecore_ctrl.sv
module lecore_ctrl
  import lecore_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  output ctlStrobe_t strobe
);
  cycState_t state, stateNext;
  logic isLoad, isStore, writesReg;

  always_comb begin
    isLoad  = (opcode == OP_LW);
    isStore = (opcode == OP_SW);
    unique case (opcode)
      OP_RTYPE, OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI, OP_LW, OP_JAL: writesReg = 1'b1;
      default: writesReg = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_FETCH_ISSUE:   stateNext = ST_FETCH_CAPTURE;
      ST_FETCH_CAPTURE: stateNext = ST_EXECUTE;
      ST_EXECUTE:       stateNext = ST_DATA;
      ST_DATA:          stateNext = ST_RETIRE;
      default:          stateNext = ST_FETCH_ISSUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH_ISSUE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_FETCH_ISSUE:   strobe.fetch  = 1'b1;
      ST_FETCH_CAPTURE: strobe.irLoad = 1'b1;
      ST_EXECUTE:       strobe.exLoad = 1'b1;
      ST_DATA: begin
        strobe.memRd = isLoad;
        strobe.memWr = isStore;
      end
      default: begin
        strobe.regWrite = writesReg;
        strobe.wbSelMem = isLoad;
        strobe.pcLoad   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lecore_dpath.sv
module lecore_dpath
  import lecore_pkg::*;
#(
  parameter logic [XLEN-1:0] ROM_BASE = 32'h0000_4000,
  parameter logic [XLEN-1:0] ALT_BASE = 32'h0000_C000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bootSel,
  input  ctlStrobe_t      strobe,
  input  logic [XLEN-1:0] memRdata,
  output logic [5:0]      opcode,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata
);
  logic [XLEN-1:0] regFile [REG_COUNT];
  logic [XLEN-1:0] pc, ir, addrR, storeR, resultR, nextPcR;

  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, destIdx;
  logic [4:0]        shamt;
  logic [5:0]        funct;
  logic [15:0]       imm16;
  logic [25:0]       jIndex;
  logic [XLEN-1:0]   rsVal, rtVal, immSx, immZx, opB, aluY, pcPlus4, branchOff, nextPc;
  aluOp_t            aluOp;

  assign opcode = ir[31:26];
  assign rsIdx  = ir[25:21];
  assign rtIdx  = ir[20:16];
  assign rdIdx  = ir[15:11];
  assign shamt  = ir[10:6];
  assign funct  = ir[5:0];
  assign imm16  = ir[15:0];
  assign jIndex = ir[25:0];

  assign rsVal     = (rsIdx == '0) ? '0 : regFile[rsIdx];
  assign rtVal     = (rtIdx == '0) ? '0 : regFile[rtIdx];
  assign immSx     = {{(XLEN-16){imm16[15]}}, imm16};
  assign immZx     = {{(XLEN-16){1'b0}}, imm16};
  assign pcPlus4   = pc + XLEN'(4);
  assign branchOff = {immSx[XLEN-3:0], 2'b00};

  always_comb begin
    aluOp = ALU_ADD;
    opB   = immSx;
    unique case (opcode)
      OP_RTYPE: begin
        opB = rtVal;
        unique case (funct)
          FN_SUB, FN_SUBU: aluOp = ALU_SUB;
          FN_AND:  aluOp = ALU_AND;
          FN_OR:   aluOp = ALU_OR;
          FN_XOR:  aluOp = ALU_XOR;
          FN_NOR:  aluOp = ALU_NOR;
          FN_SLT:  aluOp = ALU_SLT;
          FN_SLTU: aluOp = ALU_SLTU;
          FN_SLL:  aluOp = ALU_SLL;
          FN_SRL:  aluOp = ALU_SRL;
          FN_SRA:  aluOp = ALU_SRA;
          default: aluOp = ALU_ADD;
        endcase
      end
      OP_SLTI:  aluOp = ALU_SLT;
      OP_SLTIU: aluOp = ALU_SLTU;
      OP_ANDI:  begin aluOp = ALU_AND;  opB = immZx; end
      OP_ORI:   begin aluOp = ALU_OR;   opB = immZx; end
      OP_XORI:  begin aluOp = ALU_XOR;  opB = immZx; end
      OP_LUI:   begin aluOp = ALU_HIGH; opB = immZx; end
      default:  aluOp = ALU_ADD;
    endcase
  end

  lecore_alu #(.W(XLEN)) uAlu (
    .op(aluOp), .a(rsVal), .b(opB), .shamt(shamt), .y(aluY)
  );

  always_comb begin
    nextPc = pcPlus4;
    if (opcode == OP_J || opcode == OP_JAL)
      nextPc = {pcPlus4[XLEN-1:XLEN-4], jIndex, 2'b00};
    else if ((opcode == OP_BEQ && rsVal == rtVal) ||
             (opcode == OP_BNE && rsVal != rtVal))
      nextPc = pcPlus4 + branchOff;
  end

  always_comb begin
    unique case (opcode)
      OP_RTYPE: destIdx = rdIdx;
      OP_JAL:   destIdx = REG_AW'(LINK_REG);
      default:  destIdx = rtIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= bootSel ? ALT_BASE : ROM_BASE;
      ir      <= '0;
      addrR   <= '0;
      storeR  <= '0;
      resultR <= '0;
      nextPcR <= '0;
    end else begin
      if (strobe.irLoad) ir <= memRdata;
      if (strobe.exLoad) begin
        addrR   <= aluY;
        storeR  <= rtVal;
        resultR <= (opcode == OP_JAL) ? pcPlus4 : aluY;
        nextPcR <= nextPc;
      end
      if (strobe.pcLoad) pc <= nextPcR;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strobe.regWrite && destIdx != '0)
      regFile[destIdx] <= strobe.wbSelMem ? memRdata : resultR;
  end

  assign memAddr  = strobe.fetch ? pc : ((strobe.memRd | strobe.memWr) ? addrR : '0);
  assign memWdata = strobe.memWr ? storeR : '0;
endmodule

// File: rtl/lecore_top.sv
module lecore_top
  import lecore_pkg::*;
#(
  parameter logic [31:0] ROM_BASE = 32'h0000_4000,
  parameter logic [31:0] ALT_BASE = 32'h0000_C000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bootSel,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic [3:0]  memBe,
  output logic        memRd,
  output logic        memWr
);
  ctlStrobe_t ctlBus;
  logic [5:0] opcode;

  lecore_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .strobe(ctlBus)
  );

  lecore_dpath #(.ROM_BASE(ROM_BASE), .ALT_BASE(ALT_BASE)) uDpath (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .strobe(ctlBus),
    .memRdata(memRdata), .opcode(opcode), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memRd = ctlBus.fetch | ctlBus.memRd;
  assign memWr = ctlBus.memWr;
  assign memBe = (memRd | memWr) ? 4'hF : 4'h0;
endmodule

// File: rtl/lecore_chk.sv
module lecore_chk #(
  parameter logic [31:0] ROM_BASE = 32'h0000_4000,
  parameter logic [31:0] ALT_BASE = 32'h0000_C000
) (
  input logic        clk,
  input logic        rstN,
  input logic        bootSel,
  input logic        fetch,
  input logic        memRd,
  input logic        memWr,
  input logic [3:0]  memBe,
  input logic [31:0] memAddr
);
  logic [2:0] gapCnt;
  logic       firstPending;
  logic       bootLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt       <= 3'd4;
      firstPending <= 1'b1;
      bootLatch    <= bootSel;
    end else begin
      if (fetch) begin
        gapCnt       <= 3'd0;
        firstPending <= 1'b0;
      end else if (gapCnt != 3'd7) begin
        gapCnt <= gapCnt + 3'd1;
      end
    end
  end

  AST_FETCH_GAP: assert property (@(posedge clk) disable iff (!rstN)
    fetch |-> gapCnt == 3'd4);                                         // R1
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt == 3'd4 |-> fetch);                                         // R1
  AST_FETCH_ON_PORT: assert property (@(posedge clk) disable iff (!rstN)
    fetch |-> (memRd && memAddr[1:0] == 2'b00));                       // R1
  AST_BOOT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (fetch && firstPending) |-> memAddr == (bootLatch ? ALT_BASE : ROM_BASE)); // R2
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));                                                // R10
  AST_FULL_BE: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> memBe == 4'hF);                               // R7
endmodule

bind lecore_top lecore_chk #(.ROM_BASE(ROM_BASE), .ALT_BASE(ALT_BASE)) uChk (
  .clk(clk), .rstN(rstN), .bootSel(bootSel), .fetch(ctlBus.fetch),
  .memRd(memRd), .memWr(memWr), .memBe(memBe), .memAddr(memAddr)
);

// File: tb/tb_lecore_top.sv
module tb_lecore_top;
  localparam logic [31:0] BASE_LO = 32'h0000_4000;
  localparam logic [31:0] BASE_HI = 32'h0000_C000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootSel = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic        memRd, memWr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] mem [4096];

  always #4 clk = ~clk;

  lecore_top dut (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memBe(memBe),
    .memRd(memRd), .memWr(memWr)
  );

  // behavioural memory, 4 KiB window, little-endian, read data one cycle late
  always @(posedge clk) begin
    if (memWr) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[{memAddr[11:2], 2'b00} + 12'(b)] <= memWdata[8*b +: 8];
    end
    if (memRd)
      memRdata <= {mem[{memAddr[11:2], 2'b11}], mem[{memAddr[11:2], 2'b10}],
                   mem[{memAddr[11:2], 2'b01}], mem[{memAddr[11:2], 2'b00}]};
  end

  function automatic logic [31:0] encR(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                       logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encJ(logic [5:0] op, logic [31:0] target);
    return {op, target[27:2]};
  endfunction

  task automatic putWord(logic [31:0] addr, logic [31:0] w);
    for (int b = 0; b < 4; b++) mem[addr[11:0] + 12'(b)] = w[8*b +: 8];
  endtask
  function automatic logic [31:0] getWord(logic [31:0] addr);
    return {mem[addr[11:0] + 12'd3], mem[addr[11:0] + 12'd2],
            mem[addr[11:0] + 12'd1], mem[addr[11:0]]};
  endfunction
  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // hold reset, then release at a negedge; outputs are sampled 1 ns later
  task automatic startRun(logic bootHigh);
    @(negedge clk);
    rstN = 1'b0;
    bootSel = bootHigh;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask
  task automatic runInstr(int n);
    repeat (n * 5) @(negedge clk);
    #1;
  endtask

  // R1 R2 R10: first fetch after reset, fetch cadence, no stray strobes
  task automatic testFetchCadence();
    int bad = 0;
    int stray = 0;
    clearMem();
    for (int i = 0; i < 6; i++) putWord(BASE_LO + 4*i, encI(6'h08, 5'd0, 5'(i + 1), 16'(i)));
    putWord(BASE_LO + 24, encJ(6'h02, BASE_LO + 24));
    @(negedge clk);
    rstN = 1'b0;
    bootSel = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 no write in reset", {31'd0, memWr}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 low boot address", memAddr, BASE_LO);
    for (int c = 0; c < 30; c++) begin
      if (c % 5 == 0) begin
        if (memRd !== 1'b1 || memAddr !== BASE_LO + 32'(4 * (c / 5))) bad++;
      end else if (memRd !== 1'b0) begin
        bad++;
      end
      if (memWr !== 1'b0) stray++;
      @(negedge clk);
      #1;
    end
    check("R1 fetch every fifth cycle", 32'(bad), 32'd0);
    check("R10 no write strobe without store", 32'(stray), 32'd0);
  endtask

  // R5 R7: lui/ori pair and little-endian store
  task automatic testLuiOri();
    clearMem();
    putWord(BASE_LO + 0,  encI(6'h0F, 5'd0, 5'd8, 16'h1234));
    putWord(BASE_LO + 4,  encI(6'h0D, 5'd8, 5'd8, 16'h9978));
    putWord(BASE_LO + 8,  encI(6'h2B, 5'd0, 5'd8, 16'h0800));
    putWord(BASE_LO + 12, encJ(6'h02, BASE_LO + 12));
    startRun(1'b0);
    runInstr(4);
    check("R5 lui+ori", getWord(32'h800), 32'h1234_9978);
    check("R7 low byte at low address", {24'd0, mem[12'h800]}, 32'h78);
    check("R7 high byte at high address", {24'd0, mem[12'h803]}, 32'h12);
  endtask

  // R4: immediate extension rules
  task automatic testImmediates();
    clearMem();
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd9,  16'hFFFF));
    putWord(BASE_LO + 4,  encI(6'h0D, 5'd0, 5'd10, 16'hFFFF));
    putWord(BASE_LO + 8,  encI(6'h0E, 5'd9, 5'd11, 16'h8000));
    putWord(BASE_LO + 12, encI(6'h0C, 5'd9, 5'd12, 16'h8001));
    putWord(BASE_LO + 16, encI(6'h0A, 5'd9, 5'd13, 16'h0001));
    putWord(BASE_LO + 20, encI(6'h0B, 5'd0, 5'd14, 16'hFFFF));
    for (int i = 0; i < 6; i++)
      putWord(BASE_LO + 24 + 4*i, encI(6'h2B, 5'd0, 5'(9 + i), 16'(12'h800 + 4*i)));
    putWord(BASE_LO + 48, encJ(6'h02, BASE_LO + 48));
    startRun(1'b0);
    runInstr(13);
    check("R4 addi sign-extends", getWord(32'h800), 32'hFFFF_FFFF);
    check("R4 ori zero-extends", getWord(32'h804), 32'h0000_FFFF);
    check("R4 xori zero-extends", getWord(32'h808), 32'hFFFF_7FFF);
    check("R4 andi zero-extends", getWord(32'h80C), 32'h0000_8001);
    check("R4 slti signed", getWord(32'h810), 32'h1);
    check("R4 sltiu sign-extended unsigned", getWord(32'h814), 32'h1);
  endtask

  // R3: register-register operations
  task automatic testRegOps();
    logic [31:0] exp [9] = '{32'h4, 32'hA, 32'h1, 32'h0, 32'h70, 32'hFFFF_FFFE,
                             32'hF, 32'hFFFF_FFF8, 32'hFFFF_FFFA};
    clearMem();
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd1, 16'h0007));
    putWord(BASE_LO + 4,  encI(6'h08, 5'd0, 5'd2, 16'hFFFD));
    putWord(BASE_LO + 8,  encR(6'h20, 5'd1, 5'd2, 5'd3,  5'd0));
    putWord(BASE_LO + 12, encR(6'h22, 5'd1, 5'd2, 5'd4,  5'd0));
    putWord(BASE_LO + 16, encR(6'h2A, 5'd2, 5'd1, 5'd5,  5'd0));
    putWord(BASE_LO + 20, encR(6'h2B, 5'd2, 5'd1, 5'd6,  5'd0));
    putWord(BASE_LO + 24, encR(6'h00, 5'd0, 5'd1, 5'd7,  5'd4));
    putWord(BASE_LO + 28, encR(6'h03, 5'd0, 5'd2, 5'd13, 5'd1));
    putWord(BASE_LO + 32, encR(6'h02, 5'd0, 5'd2, 5'd14, 5'd28));
    putWord(BASE_LO + 36, encR(6'h27, 5'd1, 5'd0, 5'd15, 5'd0));
    putWord(BASE_LO + 40, encR(6'h26, 5'd1, 5'd2, 5'd16, 5'd0));
    putWord(BASE_LO + 44, encI(6'h2B, 5'd0, 5'd3,  16'h0800));
    putWord(BASE_LO + 48, encI(6'h2B, 5'd0, 5'd4,  16'h0804));
    putWord(BASE_LO + 52, encI(6'h2B, 5'd0, 5'd5,  16'h0808));
    putWord(BASE_LO + 56, encI(6'h2B, 5'd0, 5'd6,  16'h080C));
    putWord(BASE_LO + 60, encI(6'h2B, 5'd0, 5'd7,  16'h0810));
    putWord(BASE_LO + 64, encI(6'h2B, 5'd0, 5'd13, 16'h0814));
    putWord(BASE_LO + 68, encI(6'h2B, 5'd0, 5'd14, 16'h0818));
    putWord(BASE_LO + 72, encI(6'h2B, 5'd0, 5'd15, 16'h081C));
    putWord(BASE_LO + 76, encI(6'h2B, 5'd0, 5'd16, 16'h0820));
    putWord(BASE_LO + 80, encJ(6'h02, BASE_LO + 80));
    startRun(1'b0);
    runInstr(21);
    for (int i = 0; i < 9; i++)
      check($sformatf("R3 reg op #%0d", i), getWord(32'h800 + 32'(4*i)), exp[i]);
  endtask

  // R6: register 0 discards writes and reads as zero
  task automatic testZeroReg();
    clearMem();
    putWord(32'h800, 32'hDEAD_BEEF);
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd0, 16'h0005));
    putWord(BASE_LO + 4,  encI(6'h0D, 5'd0, 5'd0, 16'h0077));
    putWord(BASE_LO + 8,  encI(6'h0F, 5'd0, 5'd0, 16'hABCD));
    putWord(BASE_LO + 12, encI(6'h08, 5'd0, 5'd17, 16'h0003));
    putWord(BASE_LO + 16, encI(6'h2B, 5'd0, 5'd0,  16'h0800));
    putWord(BASE_LO + 20, encI(6'h2B, 5'd0, 5'd17, 16'h0804));
    putWord(BASE_LO + 24, encJ(6'h02, BASE_LO + 24));
    startRun(1'b0);
    runInstr(7);
    check("R6 r0 stored as zero", getWord(32'h800), 32'h0);
    check("R6 r0 used as source", getWord(32'h804), 32'h3);
  endtask

  // R7: load word with base+offset, little-endian assembly
  task automatic testLoadStore();
    clearMem();
    mem[12'h900] = 8'h11; mem[12'h901] = 8'h22; mem[12'h902] = 8'h33; mem[12'h903] = 8'h44;
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd4, 16'h08F0));
    putWord(BASE_LO + 4,  encI(6'h23, 5'd4, 5'd5, 16'h0010));
    putWord(BASE_LO + 8,  encI(6'h2B, 5'd4, 5'd5, 16'hFFF8));
    putWord(BASE_LO + 12, encJ(6'h02, BASE_LO + 12));
    startRun(1'b0);
    runInstr(4);
    check("R7 lw assembles little-endian", getWord(32'h8E8), 32'h4433_2211);
    check("R7 sw negative offset byte 0", {24'd0, mem[12'h8E8]}, 32'h11);
  endtask

  // R8: branches, not-taken, taken, backward loop, no delay slot
  task automatic testBranches();
    clearMem();
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd1, 16'h0001));
    putWord(BASE_LO + 4,  encI(6'h08, 5'd0, 5'd2, 16'h0011));
    putWord(BASE_LO + 8,  encI(6'h04, 5'd1, 5'd0, 16'h0001));
    putWord(BASE_LO + 12, encI(6'h08, 5'd2, 5'd2, 16'h0100));
    putWord(BASE_LO + 16, encI(6'h05, 5'd1, 5'd0, 16'h0001));
    putWord(BASE_LO + 20, encI(6'h08, 5'd0, 5'd2, 16'h0022));
    putWord(BASE_LO + 24, encI(6'h08, 5'd0, 5'd3, 16'h0003));
    putWord(BASE_LO + 28, encI(6'h08, 5'd0, 5'd4, 16'h0000));
    putWord(BASE_LO + 32, encI(6'h08, 5'd4, 5'd4, 16'h0001));
    putWord(BASE_LO + 36, encI(6'h08, 5'd3, 5'd3, 16'hFFFF));
    putWord(BASE_LO + 40, encI(6'h05, 5'd3, 5'd0, 16'hFFFD));
    putWord(BASE_LO + 44, encI(6'h2B, 5'd0, 5'd2, 16'h0800));
    putWord(BASE_LO + 48, encI(6'h2B, 5'd0, 5'd4, 16'h0804));
    putWord(BASE_LO + 52, encJ(6'h02, BASE_LO + 52));
    startRun(1'b0);
    runInstr(20);
    check("R8 beq fall-through and bne skip", getWord(32'h800), 32'h111);
    check("R8 backward bne loop count", getWord(32'h804), 32'h3);
  endtask

  // R9: jal link value and j skipping
  task automatic testJumps();
    clearMem();
    putWord(BASE_LO + 0,  encI(6'h08, 5'd0, 5'd6, 16'h0001));
    putWord(BASE_LO + 4,  encJ(6'h03, BASE_LO + 16));
    putWord(BASE_LO + 8,  encI(6'h08, 5'd0, 5'd6, 16'h0066));
    putWord(BASE_LO + 12, encI(6'h08, 5'd0, 5'd6, 16'h0066));
    putWord(BASE_LO + 16, encI(6'h2B, 5'd0, 5'd31, 16'h0800));
    putWord(BASE_LO + 20, encJ(6'h02, BASE_LO + 28));
    putWord(BASE_LO + 24, encI(6'h08, 5'd0, 5'd6, 16'h0077));
    putWord(BASE_LO + 28, encI(6'h2B, 5'd0, 5'd6, 16'h0804));
    putWord(BASE_LO + 32, encJ(6'h02, BASE_LO + 32));
    startRun(1'b0);
    runInstr(7);
    check("R9 jal links PC+4", getWord(32'h800), BASE_LO + 32'h8);
    check("R9 j and jal skip their fall-through", getWord(32'h804), 32'h1);
  endtask

  // R2 R9: high boot address, later bootSel change ignored
  task automatic testBootHigh();
    clearMem();
    putWord(BASE_HI + 0,  encJ(6'h03, BASE_HI + 8));
    putWord(BASE_HI + 4,  encI(6'h08, 5'd0, 5'd6, 16'h0066));
    putWord(BASE_HI + 8,  encI(6'h2B, 5'd0, 5'd31, 16'h0800));
    putWord(BASE_HI + 12, encJ(6'h02, BASE_HI + 12));
    startRun(1'b1);
    check("R2 high boot address", memAddr, BASE_HI);
    bootSel = 1'b0;
    runInstr(4);
    check("R2 bootSel after reset ignored", getWord(32'h800), BASE_HI + 32'h4);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    testFetchCadence();
    testLuiOri();
    testImmediates();
    testRegOps();
    testZeroReg();
    testLoadStore();
    testBranches();
    testJumps();
    testBootHigh();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end
endmodule